// File: doc/BRIEF.md
# Comma-Framed Serial-to-Parallel Symbol Aligner

The block takes a retimed serial bit stream, one bit per clock, and gathers it into 10-bit parallel symbols. The bit that arrives first in a symbol lands in symbol bit 0. Two receive strobes, an even one and an odd one, take turns marking each finished symbol. When comma search is enabled, the block watches a sliding window at every bit position for the seven-bit prefix of a positive-disparity K28.5 character. When it finds one, it moves its symbol boundary so that later commas come out with their first bit in bit 0. It also sets the strobe phase so that every four-symbol ordered set begins on the odd strobe.

The block never shortens a strobe period when it changes alignment. Instead, the realignment holds back the strobe that would have come next and starts symbol counting again from the comma boundary. If the strobe phase is also wrong, one more symbol slot passes without a strobe. The comma that caused the realignment, and in the wrong-phase case the symbol after it, is not presented. From the next ordered set onward, every symbol is presented in order. A detect output pulses for one clock whenever a comma is seen while search is enabled.

Top module: `comma_aligner`

## Requirements
- R1: While reset is asserted and before the first complete symbol, `sym_o` is zero and `stb_even_o`, `stb_odd_o` and `comma_o` are low.
- R2: Each presented symbol holds ten consecutive stream bits. The earliest-arriving bit is in bit 0. The symbol appears on the clock edge that samples its last bit.
- R3: With search enabled, a comma (arrival order 0,0,1,1,1,1,1, i.e. `sym_o[6:0] == 7'b1111100`) at any bit offset and either strobe phase causes every later comma to be presented with its first bit in bit 0. Each such comma is on the odd strobe, so the even strobe never carries a comma.
- R4: Presented symbols alternate strictly between the even strobe and the odd strobe. The two strobes are never high together.
- R5: Two successive symbol strobes are never closer than 10 clocks, including across a realignment.
- R6: A comma found at the current boundary and on the odd-strobe phase changes nothing. Symbols keep coming exactly every 10 clocks.
- R7: With search enabled, `comma_o` pulses for one clock for each comma in the stream. When a strobe occurs in the same clock, it is the odd strobe and the symbol is the comma.
- R8: With search disabled, `comma_o` stays low and the symbol boundary and strobe phase are kept, with a strobe every 10 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_i | input | 1 | Retimed serial data bit |
| det_en_i | input | 1 | Comma search enable |
| sym_o | output | 10 | Parallel symbol, bit 0 arrived first |
| stb_even_o | output | 1 | One-clock strobe for even-phase symbols |
| stb_odd_o | output | 1 | One-clock strobe for odd-phase symbols; ordered sets start here |
| comma_o | output | 1 | One-clock pulse when a comma is detected |

## Verification
The hardest case to reach is a comma that lands on the correct bit boundary while the strobe phase is wrong. Handling it needs an extra skipped slot, and a wrong design would send two even strobes close together. The stimulus reaches every combination of bit offset and strobe phase by sweeping a prefix of 0 to 19 non-comma bits before a train of ordered sets. The filler symbols contain no run of more than three ones, so the only prefix match in the stream is at each real comma. The bench then checks strobe spacing, alternation and the order of the presented symbols against the transmitted list.

// File: rtl/ba_pkg.sv
package ba_pkg;
  parameter int unsigned SYM_W = 10;
  parameter int unsigned PFX_W = 7;
  localparam int unsigned CNT_W = $clog2(SYM_W);
  // prefix in arrival order, oldest bit at index 0
  localparam logic [PFX_W-1:0] COMMA_PFX = 7'b1111100;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;
endpackage

// File: rtl/ba_rst_sync.sv
module ba_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ba_shift.sv
module ba_shift #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-1:0] win_q, win_d;

  // newest bit enters at the top, oldest sits at index 0
  always_comb begin
    win_d = {bit_i, win_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win_o = win_d;
endmodule

// File: rtl/ba_match.sv
module ba_match #(
  parameter int unsigned W   = 10,
  parameter int unsigned PW  = 7,
  parameter logic [PW-1:0] PAT = '0
) (
  input  logic [W-1:0] win_i,
  output logic         hit_o
);
  logic [PW-1:0] eq;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign eq[i] = (win_i[i] == PAT[i]);
  end

  assign hit_o = &eq;
endmodule

// File: rtl/ba_framer.sv
module ba_framer
  import ba_pkg::*;
#(
  parameter int unsigned W  = SYM_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         hit_i,
  input  logic [W-1:0] win_i,
  output logic [W-1:0] sym_o,
  output logic         stb_even_o,
  output logic         stb_odd_o,
  output logic         det_o
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  phase_e        ph_q, ph_d;
  logic          skip_q, skip_d;
  logic [W-1:0]  sym_q;
  logic          ev_q, od_q, det_q;

  logic slot_end, on_frame, realign, emit;

  always_comb begin
    slot_end = (cnt_q == LAST);
    on_frame = slot_end && (ph_q == PH_ODD) && !skip_q;
    realign  = en_i && hit_i && !on_frame;
    emit     = slot_end && !skip_q && !realign;

    cnt_d  = (realign || slot_end) ? '0 : cnt_q + 1'b1;
    skip_d = skip_q;
    if (realign)       skip_d = (ph_q == PH_ODD);
    else if (slot_end) skip_d = 1'b0;
    ph_d = ph_q;
    if (emit) ph_d = (ph_q == PH_ODD) ? PH_EVEN : PH_ODD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= PH_EVEN;
      skip_q <= 1'b0;
      sym_q  <= '0;
      ev_q   <= 1'b0;
      od_q   <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      skip_q <= skip_d;
      if (emit) sym_q <= win_i;
      ev_q   <= emit && (ph_q == PH_EVEN);
      od_q   <= emit && (ph_q == PH_ODD);
      det_q  <= en_i && hit_i;
    end
  end

  assign sym_o      = sym_q;
  assign stb_even_o = ev_q;
  assign stb_odd_o  = od_q;
  assign det_o      = det_q;
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import ba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_i,
  input  logic             det_en_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             stb_even_o,
  output logic             stb_odd_o,
  output logic             comma_o
);
  logic             rst_n_s;
  logic [SYM_W-1:0] win;
  logic             hit;

  ba_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  ba_shift #(.W(SYM_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n_s),
    .bit_i (ser_i),
    .win_o (win)
  );

  ba_match #(.W(SYM_W), .PW(PFX_W), .PAT(COMMA_PFX)) u_match (
    .win_i (win),
    .hit_o (hit)
  );

  ba_framer #(.W(SYM_W), .CW(CNT_W)) u_frm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en_i       (det_en_i),
    .hit_i      (hit),
    .win_i      (win),
    .sym_o      (sym_o),
    .stb_even_o (stb_even_o),
    .stb_odd_o  (stb_odd_o),
    .det_o      (comma_o)
  );
endmodule

// File: rtl/ba_chk.sv
module ba_chk
  import ba_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             det_en_i,
  input logic [SYM_W-1:0] sym_o,
  input logic             stb_even_o,
  input logic             stb_odd_o,
  input logic             comma_o
);
  localparam int unsigned GW  = $clog2(2 * SYM_W + 2);
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap_q;
  logic [1:0]    last_q; // 0 none, 1 even, 2 odd
  logic          stb;

  assign stb = stb_even_o || stb_odd_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GMAX;
      last_q <= 2'd0;
    end else begin
      if (stb)               gap_q <= '0;
      else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
      if (stb_even_o)     last_q <= 2'd1;
      else if (stb_odd_o) last_q <= 2'd2;
    end
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_even_o, stb_odd_o}));

  assert_even_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_even_o |-> (last_q != 2'd1));

  assert_odd_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_odd_o |-> (last_q != 2'd2));

  assert_no_short_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (gap_q >= GW'(SYM_W - 1)));

  assert_no_comma_on_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_even_o && $past(det_en_i)) |-> (sym_o[PFX_W-1:0] != COMMA_PFX));

  assert_detect_with_comma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_o && stb) |-> (stb_odd_o && sym_o[PFX_W-1:0] == COMMA_PFX));

  assert_detect_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    comma_o |=> !comma_o);

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(det_en_i) |-> !comma_o);
endmodule

bind comma_aligner ba_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_en_i   (det_en_i),
  .sym_o      (sym_o),
  .stb_even_o (stb_even_o),
  .stb_odd_o  (stb_odd_o),
  .comma_o    (comma_o)
);

// File: tb/sim_comma_aligner.sv
module sim_comma_aligner;
  localparam int NSYM  = 24;
  localparam logic [9:0] COMMA = 10'h17C;
  localparam logic [9:0] FMASK = 10'h2DB;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_i;
  logic       det_en_i;
  logic [9:0] sym_o;
  logic       stb_even_o, stb_odd_o, comma_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [9:0] esym [0:63];
  int  ne, ndet, ncomma_odd, ncomma_even, cyc, last_cyc, last_id;
  bit  gap_bad, alt_bad, steady_bad, seen_comma, all10_bad;

  always #2 clk = ~clk;

  comma_aligner u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_i      (ser_i),
    .det_en_i   (det_en_i),
    .sym_o      (sym_o),
    .stb_even_o (stb_even_o),
    .stb_odd_o  (stb_odd_o),
    .comma_o    (comma_o)
  );

  function automatic logic [9:0] sent_sym(input int j);
    if (j % 4 == 0) return COMMA;
    return 10'((j * 37 + 5)) & FMASK;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample what the previous edge produced, then drive the next bit
  task automatic step(input logic b);
    @(negedge clk);
    cyc++;
    if (comma_o) ndet++;
    if (stb_even_o || stb_odd_o) begin
      if (ne < 64) esym[ne] = sym_o;
      ne++;
      if (last_cyc >= 0 && cyc - last_cyc < 10) gap_bad = 1;
      if (last_cyc >= 0 && cyc - last_cyc != 10) all10_bad = 1;
      if (seen_comma && cyc - last_cyc != 10) steady_bad = 1;
      if ((stb_even_o && last_id == 0) || (stb_odd_o && last_id == 1)) alt_bad = 1;
      last_id  = stb_odd_o ? 1 : 0;
      last_cyc = cyc;
      if (sym_o == COMMA) begin
        if (stb_odd_o && comma_o) ncomma_odd++;
        else ncomma_even++;
        seen_comma = 1;
      end
    end
    ser_i = b;
  endtask

  task automatic run_case(input int p, input bit en);
    ne = 0; ndet = 0; ncomma_odd = 0; ncomma_even = 0; cyc = 0;
    last_cyc = -1; last_id = -1;
    gap_bad = 0; alt_bad = 0; steady_bad = 0; seen_comma = 0; all10_bad = 0;
    det_en_i = en;
    ser_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sym_o == 10'd0 && !stb_even_o && !stb_odd_o && !comma_o, "R1 reset outputs",
        int'({sym_o, stb_even_o, stb_odd_o, comma_o}), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0);
    for (int q = 0; q < p; q++) step(FMASK[q % 10]);
    for (int j = 0; j < NSYM; j++) begin
      logic [9:0] s;
      s = sent_sym(j);
      for (int k = 0; k < 10; k++) step(s[k]);
    end
    step(1'b0);

    chk(!gap_bad, "R5 strobe spacing >= 10", int'(gap_bad), 0);
    chk(!alt_bad, "R4 strobe alternation", int'(alt_bad), 0);
    if (en) begin
      chk(ncomma_odd >= 5, "R3 aligned commas on odd strobe", ncomma_odd, 5);
      chk(ncomma_even == 0, "R3 no comma on even strobe", ncomma_even, 0);
      chk(ndet == NSYM / 4, "R7 detect pulse count", ndet, NSYM / 4);
      chk(!steady_bad, "R6 no change once aligned", int'(steady_bad), 0);
      for (int i = 0; i < 20; i++) begin
        int idx;
        idx = ne - 20 + i;
        chk(idx >= 0 && idx < 64 && esym[idx] == sent_sym(NSYM - 20 + i),
            "R2 symbol order and bit order",
            (idx >= 0 && idx < 64) ? int'(esym[idx]) : -1, int'(sent_sym(NSYM - 20 + i)));
      end
    end else begin
      chk(ndet == 0, "R8 no detect when disabled", ndet, 0);
      chk(!all10_bad, "R8 framing kept when disabled", int'(all10_bad), 0);
      if ((p + 3) % 10 != 0)
        chk(ncomma_odd + ncomma_even == 0, "R8 misaligned commas stay split",
            ncomma_odd + ncomma_even, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ser_i = 1'b0;
    det_en_i = 1'b0;
    for (int p = 0; p < 20; p++) run_case(p, 1'b1);
    run_case(3, 1'b0);
    run_case(14, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule